// File: doc/BRIEF.md
# Floppy Controller Register-Command Engine

This block presents the host-facing register file of a floppy disk controller and runs its command timing. A host reaches four byte-wide registers through a 2-bit offset: command (write) / status (read), track, sector and data. A byte written to the command register is decoded and starts a fixed-length sequence: a prepare phase, then an execute phase, then idle. The status register shows whether the engine is executing, whether it is ready to move a data byte, and whether the head is at track zero.

Sector commands compute the byte address of the selected sector from the track register, the sector register and a side input sampled when the command is written. Bytes then stream through the data register to a synchronous byte-wide memory port that stands in for the disk image. Every byte moved restarts the execute timer, so a host that keeps up keeps the command alive; a single-sector transfer stops itself at the end of the sector, while a multi-sector transfer runs on until the host forces an interrupt.

Reads of the data register wait one extra cycle for the memory, so read results come back with a one-cycle acknowledge pulse, one cycle after the request for registers and two cycles after it for transferred bytes.

Top module: `fdc_cmd_engine`

## Requirements
- R1: Offset 1 is the track register and offset 2 the sector register; a byte written there reads back unchanged. After reset status reads 0x80, track and sector read 0 and the error flag is low. A non-data register read is acknowledged one cycle after the request.
- R2: Status bit 7 always reads 1 and status bits 6 to 3 always read 0.
- R3: Writing command codes 0x00, 0x10, 0x14, 0x80, 0x90, 0xA0, 0xA2, 0xF0 or 0xF2 gives 5 cycles of prepare, then 5 cycles of execute, then idle; status bit 0 (busy) is 1 exactly in execute.
- R4: Status bit 1 (data request) is 1 only in execute, and only when the running command is 0x80, 0x90, 0xA0 or 0xA2.
- R5: Code 0x00 clears the track register and sets status bit 2 (track zero); codes 0x10 and 0x14 copy the data register into the track register and set track zero only when that value is 0.
- R6: Codes 0x80, 0x90, 0xA0, 0xA2, 0xD0, 0xF0 and 0xF2 clear track zero.
- R7: A sector command sets the memory address to ((track x 2 + side) x 9 + sector - 1) x 512, with side taken from the side input in the cycle the command is written.
- R8: During execute of 0x80 or 0x90, each data-register read presents the current address to memory, returns the byte stored there with its acknowledge two cycles after the request, advances the address by one and restarts the 5-cycle execute timer.
- R9: Under 0x80 the engine returns to idle once the address advances onto a multiple of 512; under 0x90 it stays in execute across that point.
- R10: During execute of 0xA0 or 0xA2 a data-register write drives the memory write strobe with the byte and current address, advances the address, restarts the execute timer and ends the command on reaching a multiple of 512; a data-register write at any other time only loads the data register and never strobes memory.
- R11: Code 0xD0 puts the engine into idle at the next clock edge, abandoning any command in progress.
- R12: Codes 0xF0 and 0xF2, any code not listed in R3 or R11, and a data-register read outside execute of a read command set a sticky error flag that only reset clears; such a read returns 0, and an unlisted code leaves the sequencer and registers as they were.
- R13: A data transfer in the last execute cycle takes priority over timer expiry: the engine stays in execute with a full 5-cycle timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_sel | input | 2 | Register offset: 0 command/status, 1 track, 2 sector, 3 data |
| reg_wr | input | 1 | Register write strobe, one cycle per byte |
| reg_rd | input | 1 | Register read request, one cycle; ignored while reg_wr is high or a data read is outstanding |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read result, valid when reg_ack is high |
| reg_ack | output | 1 | One-cycle pulse marking a completed read |
| side_sel | input | 1 | Head side used by the next sector command |
| mem_addr | output | 20 | Byte address into the backing memory |
| mem_wdata | output | 8 | Byte to store |
| mem_we | output | 1 | Store strobe |
| mem_rdata | input | 8 | Byte read back, one cycle after the address |
| err_flag | output | 1 | Sticky error indication |

## Verification
The collision that matters is a data-register transfer landing in the very cycle the execute timer would expire. The bench provokes it by issuing a multi-sector read and holding off exactly nine cycles, so the first data read is accepted on the final execute edge. It judges the outcome by the returned byte matching the sector start address and by busy still reading 1 two cycles later, which only holds if the transfer won and reloaded the timer; a lost transfer would show as a zero byte, a set error flag and busy low.

// File: rtl/fdc_pkg.sv
package fdc_pkg;

  // Sequencer phases
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_PREP = 2'd1,
    PH_EXEC = 2'd2
  } phase_e;

  // Classes a command byte decodes into
  typedef enum logic [2:0] {
    K_RESTORE  = 3'd0,
    K_SEEK     = 3'd1,
    K_RD_ONE   = 3'd2,
    K_RD_MULTI = 3'd3,
    K_WR_SEC   = 3'd4,
    K_FORCE    = 3'd5,
    K_WR_TRACK = 3'd6,
    K_BAD      = 3'd7
  } cmd_kind_e;

  localparam int BYTE_W = 8;

  // Register offsets seen by the host
  localparam logic [1:0] OFS_CMD = 2'd0;
  localparam logic [1:0] OFS_TRK = 2'd1;
  localparam logic [1:0] OFS_SEC = 2'd2;
  localparam logic [1:0] OFS_DAT = 2'd3;

  // Status bit positions
  localparam int ST_BUSY  = 0;
  localparam int ST_DRQ   = 1;
  localparam int ST_TRK0  = 2;
  localparam int ST_MOTOR = 7;

endpackage

// File: rtl/fdc_rst_sync.sv
module fdc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/fdc_cmd_decode.sv
module fdc_cmd_decode
  import fdc_pkg::*;
(
  input  logic [BYTE_W-1:0] code,
  output cmd_kind_e         kind
);

  always_comb begin
    unique case (code)
      8'h00:        kind = K_RESTORE;
      8'h10, 8'h14: kind = K_SEEK;
      8'h80:        kind = K_RD_ONE;
      8'h90:        kind = K_RD_MULTI;
      8'hA0, 8'hA2: kind = K_WR_SEC;
      8'hD0:        kind = K_FORCE;
      8'hF0, 8'hF2: kind = K_WR_TRACK;
      default:      kind = K_BAD;
    endcase
  end

endmodule

// File: rtl/fdc_sequencer.sv
module fdc_sequencer
  import fdc_pkg::*;
#(
  parameter int PREP_CYC = 5,
  parameter int EXEC_CYC = 5
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   abort,
  input  logic   xfer,
  input  logic   xfer_end,
  output phase_e phase
);

  localparam int MAX_CYC = (PREP_CYC > EXEC_CYC) ? PREP_CYC : EXEC_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] PREP_LOAD = CNT_W'(PREP_CYC);
  localparam logic [CNT_W-1:0] EXEC_LOAD = CNT_W'(EXEC_CYC);
  localparam logic [CNT_W-1:0] CNT_ONE   = CNT_W'(1);

  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    if (abort) begin
      phase_d = PH_IDLE;
      cnt_d   = '0;
    end else if (start) begin
      phase_d = PH_PREP;
      cnt_d   = PREP_LOAD;
    end else begin
      unique case (phase_q)
        PH_PREP: begin
          if (cnt_q == CNT_ONE) begin
            phase_d = PH_EXEC;
            cnt_d   = EXEC_LOAD;
          end else begin
            cnt_d = cnt_q - CNT_ONE;
          end
        end
        PH_EXEC: begin
          // a moved byte outranks the timer running out
          if (xfer) begin
            if (xfer_end) begin
              phase_d = PH_IDLE;
              cnt_d   = '0;
            end else begin
              cnt_d = EXEC_LOAD;
            end
          end else if (cnt_q == CNT_ONE) begin
            phase_d = PH_IDLE;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q - CNT_ONE;
          end
        end
        default: begin
          phase_d = PH_IDLE;
          cnt_d   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  assign phase = phase_q;

endmodule

// File: rtl/fdc_sector_addr.sv
module fdc_sector_addr
  import fdc_pkg::*;
#(
  parameter int SIDES     = 2,
  parameter int SPT       = 9,
  parameter int SEC_BYTES = 512,
  parameter int ADDR_W    = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] track,
  input  logic [BYTE_W-1:0] sector,
  input  logic              side,
  input  logic              advance,
  output logic [ADDR_W-1:0] addr,
  output logic              last_byte
);

  localparam int OFF_W = $clog2(SEC_BYTES);

  logic [ADDR_W-1:0] sec_index;
  logic [ADDR_W-1:0] start_addr;
  logic [ADDR_W-1:0] addr_q, addr_d;

  // linear sector number, sectors counted from 1 inside a track
  always_comb begin
    sec_index  = ((ADDR_W'(track) * ADDR_W'(SIDES)) + ADDR_W'(side)) * ADDR_W'(SPT)
                 + ADDR_W'(sector) - ADDR_W'(1);
    start_addr = sec_index << OFF_W;
  end

  always_comb begin
    addr_d = addr_q;
    if (load) begin
      addr_d = start_addr;
    end else if (advance) begin
      addr_d = addr_q + ADDR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else begin
      addr_q <= addr_d;
    end
  end

  assign addr      = addr_q;
  assign last_byte = &addr_q[OFF_W-1:0];

endmodule

// File: rtl/fdc_cmd_engine.sv
module fdc_cmd_engine
  import fdc_pkg::*;
#(
  parameter int CYLS      = 80,
  parameter int SIDES     = 2,
  parameter int SPT       = 9,
  parameter int SEC_BYTES = 512,
  parameter int PREP_CYC  = 5,
  parameter int EXEC_CYC  = 5,
  parameter int ADDR_W    = $clog2(CYLS * SIDES * SPT * SEC_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        reg_sel,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  output logic              reg_ack,
  input  logic              side_sel,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic              mem_we,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic              err_flag
);

  logic rst_i_n;

  fdc_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  // ---------------------------------------------------------------- decode
  cmd_kind_e new_kind;

  fdc_cmd_decode u_decode (
    .code (reg_wdata),
    .kind (new_kind)
  );

  // ---------------------------------------------------------------- state
  logic [BYTE_W-1:0] trk_q, trk_d;
  logic [BYTE_W-1:0] sec_q, sec_d;
  logic [BYTE_W-1:0] dat_q, dat_d;
  logic              trk0_q, trk0_d;
  logic              err_q, err_d;
  cmd_kind_e         cur_kind_q, cur_kind_d;
  logic [BYTE_W-1:0] rdata_q, rdata_d;
  logic              ack_q, ack_d;
  logic              pend_q, pend_d;

  phase_e            seq_phase;
  logic [ADDR_W-1:0] cur_addr;
  logic              at_last_byte;

  // ---------------------------------------------------------------- strobes
  logic cmd_wr, rd_req, in_exec, is_rd_cmd, is_wr_cmd, is_sec_kind;
  logic dat_rd_ok, dat_wr_ok, xfer, xfer_end;
  logic seq_start, seq_abort, addr_load;
  logic [BYTE_W-1:0] status;

  assign cmd_wr    = reg_wr && (reg_sel == OFS_CMD);
  assign rd_req    = reg_rd && !reg_wr && !pend_q;
  assign in_exec   = (seq_phase == PH_EXEC);
  assign is_rd_cmd = (cur_kind_q == K_RD_ONE) || (cur_kind_q == K_RD_MULTI);
  assign is_wr_cmd = (cur_kind_q == K_WR_SEC);

  assign is_sec_kind = (new_kind == K_RD_ONE) || (new_kind == K_RD_MULTI) ||
                       (new_kind == K_WR_SEC);

  assign dat_rd_ok = rd_req && (reg_sel == OFS_DAT) && in_exec && is_rd_cmd;
  assign dat_wr_ok = reg_wr && (reg_sel == OFS_DAT) && in_exec && is_wr_cmd;
  assign xfer      = dat_rd_ok || dat_wr_ok;
  assign xfer_end  = at_last_byte && (dat_wr_ok || (cur_kind_q == K_RD_ONE));

  assign seq_start = cmd_wr && (new_kind != K_BAD) && (new_kind != K_FORCE);
  assign seq_abort = cmd_wr && (new_kind == K_FORCE);
  assign addr_load = cmd_wr && is_sec_kind;

  always_comb begin
    status                = '0;
    status[ST_MOTOR]      = 1'b1;
    status[ST_TRK0]       = trk0_q;
    status[ST_DRQ]        = in_exec && (is_rd_cmd || is_wr_cmd);
    status[ST_BUSY]       = in_exec;
  end

  // ---------------------------------------------------------------- sub-blocks
  fdc_sequencer #(
    .PREP_CYC (PREP_CYC),
    .EXEC_CYC (EXEC_CYC)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .start    (seq_start),
    .abort    (seq_abort),
    .xfer     (xfer),
    .xfer_end (xfer_end),
    .phase    (seq_phase)
  );

  fdc_sector_addr #(
    .SIDES     (SIDES),
    .SPT       (SPT),
    .SEC_BYTES (SEC_BYTES),
    .ADDR_W    (ADDR_W)
  ) u_addr (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .load      (addr_load),
    .track     (trk_q),
    .sector    (sec_q),
    .side      (side_sel),
    .advance   (xfer),
    .addr      (cur_addr),
    .last_byte (at_last_byte)
  );

  // ---------------------------------------------------------------- register file
  always_comb begin
    trk_d      = trk_q;
    sec_d      = sec_q;
    dat_d      = dat_q;
    trk0_d     = trk0_q;
    err_d      = err_q;
    cur_kind_d = cur_kind_q;

    if (cmd_wr) begin
      if (new_kind != K_BAD) begin
        cur_kind_d = new_kind;
      end
      unique case (new_kind)
        K_RESTORE: begin
          trk_d  = '0;
          trk0_d = 1'b1;
        end
        K_SEEK: begin
          trk_d  = dat_q;
          trk0_d = (dat_q == '0);
        end
        K_RD_ONE, K_RD_MULTI, K_WR_SEC, K_FORCE: begin
          trk0_d = 1'b0;
        end
        K_WR_TRACK: begin
          trk0_d = 1'b0;
          err_d  = 1'b1;
        end
        default: begin
          err_d = 1'b1;
        end
      endcase
    end

    if (reg_wr && (reg_sel == OFS_TRK)) begin
      trk_d = reg_wdata;
    end
    if (reg_wr && (reg_sel == OFS_SEC)) begin
      sec_d = reg_wdata;
    end
    if (reg_wr && (reg_sel == OFS_DAT) && !dat_wr_ok) begin
      dat_d = reg_wdata;
    end

    if (rd_req && (reg_sel == OFS_DAT) && !dat_rd_ok) begin
      err_d = 1'b1;
    end
  end

  // ---------------------------------------------------------------- read return
  always_comb begin
    rdata_d = rdata_q;
    ack_d   = 1'b0;
    pend_d  = 1'b0;
    if (pend_q) begin
      rdata_d = mem_rdata;
      ack_d   = 1'b1;
    end else if (rd_req) begin
      unique case (reg_sel)
        OFS_CMD: begin
          rdata_d = status;
          ack_d   = 1'b1;
        end
        OFS_TRK: begin
          rdata_d = trk_q;
          ack_d   = 1'b1;
        end
        OFS_SEC: begin
          rdata_d = sec_q;
          ack_d   = 1'b1;
        end
        default: begin
          if (dat_rd_ok) begin
            pend_d = 1'b1;
          end else begin
            rdata_d = '0;
            ack_d   = 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      trk_q      <= '0;
      sec_q      <= '0;
      dat_q      <= '0;
      trk0_q     <= 1'b0;
      err_q      <= 1'b0;
      cur_kind_q <= K_BAD;
      rdata_q    <= '0;
      ack_q      <= 1'b0;
      pend_q     <= 1'b0;
    end else begin
      trk_q      <= trk_d;
      sec_q      <= sec_d;
      dat_q      <= dat_d;
      trk0_q     <= trk0_d;
      err_q      <= err_d;
      cur_kind_q <= cur_kind_d;
      rdata_q    <= rdata_d;
      ack_q      <= ack_d;
      pend_q     <= pend_d;
    end
  end

  // ---------------------------------------------------------------- outputs
  assign reg_rdata = rdata_q;
  assign reg_ack   = ack_q;
  assign mem_addr  = cur_addr;
  assign mem_wdata = reg_wdata;
  assign mem_we    = dat_wr_ok;
  assign err_flag  = err_q;

endmodule

// File: rtl/fdc_cmd_engine_chk.sv
module fdc_cmd_engine_chk
  import fdc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        reg_sel,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [BYTE_W-1:0] reg_wdata,
  input logic [BYTE_W-1:0] reg_rdata,
  input logic              reg_ack,
  input logic              mem_we,
  input logic              err_flag,
  input phase_e            phase,
  input logic              pend
);

  logic status_req;
  assign status_req = reg_rd && !reg_wr && !pend && (reg_sel == OFS_CMD);

  AST_STATUS_FIXED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    status_req |=> (reg_ack && reg_rdata[7] && ((reg_rdata & 8'h78) == 8'h00))); // R2

  AST_IDLE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (status_req && (phase != PH_EXEC)) |=> (reg_rdata[1:0] == 2'b00)); // R3

  AST_EXEC_AFTER_PREP: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_EXEC) |-> ($past(phase) != PH_IDLE)); // R3

  AST_CMD_TO_PREP: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && (reg_sel == OFS_CMD) && (reg_wdata == 8'h90)) |=> (phase == PH_PREP)); // R3

  AST_DATA_READ_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> (!reg_ack ##1 reg_ack)); // R8

  AST_STORE_IN_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (phase == PH_EXEC)); // R10

  AST_FORCE_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && (reg_sel == OFS_CMD) && (reg_wdata == 8'hD0)) |=> (phase == PH_IDLE)); // R11

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag); // R12

endmodule

bind fdc_cmd_engine fdc_cmd_engine_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_i_n),
  .reg_sel   (reg_sel),
  .reg_wr    (reg_wr),
  .reg_rd    (reg_rd),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .reg_ack   (reg_ack),
  .mem_we    (mem_we),
  .err_flag  (err_flag),
  .phase     (seq_phase),
  .pend      (pend_q)
);

// File: tb/fdc_cmd_engine_tb_top.sv
module fdc_cmd_engine_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 20;

  logic          clk;
  logic          rst_n;
  logic [1:0]    reg_sel;
  logic          reg_wr;
  logic          reg_rd;
  logic [7:0]    reg_wdata;
  logic [7:0]    reg_rdata;
  logic          reg_ack;
  logic          side_sel;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_wdata;
  logic          mem_we;
  logic [7:0]    mem_rdata;
  logic          err_flag;

  int n_chk;
  int n_fail;
  bit done;

  fdc_cmd_engine dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_sel   (reg_sel),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .reg_ack   (reg_ack),
    .side_sel  (side_sel),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .mem_rdata (mem_rdata),
    .err_flag  (err_flag)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // backing memory model: content is a function of the address
  function automatic logic [7:0] pat(input logic [AW-1:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ {4'h0, a[19:16]} ^ 8'h5A;
  endfunction

  always @(posedge clk) mem_rdata <= pat(mem_addr);

  // ------------------------------------------------------------ helpers
  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    reg_wr = 1'b0; reg_rd = 1'b0; reg_sel = 2'd0; reg_wdata = 8'h00; side_sel = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [1:0] s, input logic [7:0] v);
    reg_sel = s; reg_wdata = v; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] s, output logic [7:0] d, output int lat);
    reg_sel = s; reg_rd = 1'b1; lat = 1;
    @(negedge clk);
    reg_rd = 1'b0;
    while (!reg_ack && lat < 4) begin
      @(negedge clk);
      lat++;
    end
    d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // ------------------------------------------------------------ vector table
  // cmd, data byte loaded first, runs, drq in exec, trk0 after, err after, track after
  typedef struct packed {
    logic [7:0] cmd;
    logic [7:0] dat;
    logic       runs;
    logic       drq;
    logic       trk0;
    logic       err;
    logic [7:0] trk;
  } vec_t;

  localparam int NVEC = 13;
  localparam vec_t VECS [NVEC] = '{
    {8'h00, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00},
    {8'h10, 8'h05, 1'b1, 1'b0, 1'b0, 1'b0, 8'h05},
    {8'h14, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00},
    {8'hD0, 8'h2A, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00},
    {8'h00, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00},
    {8'h80, 8'h11, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00},
    {8'h10, 8'h4F, 1'b1, 1'b0, 1'b0, 1'b0, 8'h4F},
    {8'h90, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 8'h4F},
    {8'hA0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 8'h4F},
    {8'hA2, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 8'h4F},
    {8'h00, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00},
    {8'hF2, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 8'h00},
    {8'hF0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 8'h00}
  };

  // ------------------------------------------------------------ watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  // ------------------------------------------------------------ main
  initial begin
    logic [7:0] d;
    logic [7:0] st;
    int lat;
    int bad;
    longint fa, fe;
    logic [AW-1:0] base;

    n_chk = 0; n_fail = 0; done = 1'b0;
    do_reset();

    // reset state
    rd_reg(2'd0, d, lat);
    chk(d == 8'h80, "R1 R2 reset status", d, 8'h80);
    chk(lat == 1, "R1 status read latency", lat, 1);
    rd_reg(2'd1, d, lat);
    chk(d == 8'h00, "R1 reset track", d, 0);
    rd_reg(2'd2, d, lat);
    chk(d == 8'h00, "R1 reset sector", d, 0);
    chk(err_flag == 1'b0, "R1 reset error flag", err_flag, 0);

    // register read-back
    wr_reg(2'd1, 8'h2C);
    rd_reg(2'd1, d, lat);
    chk(d == 8'h2C, "R1 track readback", d, 8'h2C);
    wr_reg(2'd2, 8'h07);
    rd_reg(2'd2, d, lat);
    chk(d == 8'h07, "R1 sector readback", d, 8'h07);

    // table: command timing, status bits, track effects
    for (int v = 0; v < NVEC; v++) begin
      bad = 0; fa = 0; fe = 0;
      wr_reg(2'd3, VECS[v].dat);
      wr_reg(2'd0, VECS[v].cmd);
      for (int i = 0; i < 11; i++) begin
        logic eb;
        logic [7:0] es;
        rd_reg(2'd0, st, lat);
        eb = VECS[v].runs && (i >= 5) && (i <= 9);
        es = {1'b1, 4'b0000, st[2], eb && VECS[v].drq, eb};
        if (st != es) begin
          if (bad == 0) begin fa = st; fe = es; end
          bad++;
        end
      end
      chk(bad == 0, $sformatf("R2 R3 R4 status sequence cmd %0h", VECS[v].cmd), fa, fe);
      chk(st[2] == VECS[v].trk0, $sformatf("R5 R6 track zero cmd %0h", VECS[v].cmd), st[2], VECS[v].trk0);
      rd_reg(2'd1, d, lat);
      chk(d == VECS[v].trk, $sformatf("R5 track register cmd %0h", VECS[v].cmd), d, VECS[v].trk);
      chk(err_flag == VECS[v].err, $sformatf("R12 error flag cmd %0h", VECS[v].cmd), err_flag, VECS[v].err);
    end

    // single-sector read of the last sector, side sampled at command
    do_reset();
    wr_reg(2'd1, 8'd79);
    wr_reg(2'd2, 8'd9);
    side_sel = 1'b1;
    wr_reg(2'd0, 8'h80);
    side_sel = 1'b0;
    base = 20'd736768;
    chk(mem_addr == base, "R7 sector start address", mem_addr, base);
    idle(5);
    bad = 0; fa = 0; fe = 0;
    begin
      int bad_a;
      int bad_l;
      bad_a = 0; bad_l = 0;
      for (int k = 0; k < 512; k++) begin
        if (mem_addr != base + AW'(k)) bad_a++;
        rd_reg(2'd3, d, lat);
        if (lat != 2) bad_l++;
        if (d != pat(base + AW'(k))) begin
          if (bad == 0) begin fa = d; fe = pat(base + AW'(k)); end
          bad++;
        end
      end
      chk(bad_a == 0, "R8 address advances per byte", bad_a, 0);
      chk(bad_l == 0, "R8 data read acknowledged after two cycles", bad_l, 0);
    end
    chk(bad == 0, "R8 single read byte values", fa, fe);
    rd_reg(2'd0, st, lat);
    chk(st == 8'h80, "R9 single read ends at sector end", st, 8'h80);
    chk(err_flag == 1'b0, "R12 no error on valid reads", err_flag, 0);

    // multi-sector read with transfer on the final execute cycle
    do_reset();
    wr_reg(2'd1, 8'd3);
    wr_reg(2'd2, 8'd2);
    side_sel = 1'b1;
    wr_reg(2'd0, 8'h90);
    side_sel = 1'b0;
    base = 20'd32768;
    chk(mem_addr == base, "R7 start address side one", mem_addr, base);
    idle(9);
    rd_reg(2'd3, d, lat);
    chk(d == pat(base), "R13 byte moved on last execute cycle", d, pat(base));
    rd_reg(2'd0, st, lat);
    chk(st[0] == 1'b1, "R13 transfer reloads timer over expiry", st, 8'h83);
    chk(err_flag == 1'b0, "R13 collision raises no error", err_flag, 0);
    bad = 0; fa = 0; fe = 0;
    for (int k = 1; k < 513; k++) begin
      rd_reg(2'd3, d, lat);
      if (d != pat(base + AW'(k))) begin
        if (bad == 0) begin fa = d; fe = pat(base + AW'(k)); end
        bad++;
      end
    end
    chk(bad == 0, "R9 multi read crosses sector boundary", fa, fe);
    rd_reg(2'd0, st, lat);
    chk(st == 8'h83, "R9 multi read still executing", st, 8'h83);
    chk(mem_addr == base + AW'(513), "R9 address continues into next sector", mem_addr, base + 513);
    wr_reg(2'd0, 8'hD0);
    rd_reg(2'd0, st, lat);
    chk(st == 8'h80, "R11 force interrupt idles at once", st, 8'h80);

    // sector write
    do_reset();
    wr_reg(2'd1, 8'd1);
    wr_reg(2'd2, 8'd5);
    reg_sel = 2'd3; reg_wdata = 8'h3C; reg_wr = 1'b1;
    #1;
    chk(mem_we == 1'b0, "R10 idle data write does not store", mem_we, 0);
    @(negedge clk); reg_wr = 1'b0;
    wr_reg(2'd0, 8'hA2);
    base = 20'd11264;
    reg_sel = 2'd3; reg_wdata = 8'h99; reg_wr = 1'b1;
    #1;
    chk(mem_we == 1'b0, "R10 prepare data write does not store", mem_we, 0);
    @(negedge clk); reg_wr = 1'b0;
    idle(4);
    bad = 0; fa = 0; fe = 0;
    for (int k = 0; k < 512; k++) begin
      logic [7:0] b;
      b = 8'(k) ^ 8'hC3;
      reg_sel = 2'd3; reg_wdata = b; reg_wr = 1'b1;
      #1;
      if (!(mem_we && mem_addr == base + AW'(k) && mem_wdata == b)) begin
        if (bad == 0) begin fa = {mem_we, mem_addr}; fe = {1'b1, base + AW'(k)}; end
        bad++;
      end
      @(negedge clk); reg_wr = 1'b0;
    end
    chk(bad == 0, "R10 store strobe address and byte", fa, fe);
    rd_reg(2'd0, st, lat);
    chk(st == 8'h80, "R10 write ends at sector end", st, 8'h80);
    wr_reg(2'd0, 8'h10);
    rd_reg(2'd1, d, lat);
    chk(d == 8'h99, "R10 non-transfer write loaded data register", d, 8'h99);

    // errors
    do_reset();
    wr_reg(2'd1, 8'h12);
    wr_reg(2'd0, 8'h37);
    chk(err_flag == 1'b1, "R12 unknown code sets error", err_flag, 1);
    idle(5);
    rd_reg(2'd0, st, lat);
    chk(st == 8'h80, "R12 unknown code leaves sequencer idle", st, 8'h80);
    rd_reg(2'd1, d, lat);
    chk(d == 8'h12, "R12 unknown code leaves track", d, 8'h12);
    wr_reg(2'd0, 8'h00);
    idle(11);
    chk(err_flag == 1'b1, "R12 error stays set", err_flag, 1);

    do_reset();
    rd_reg(2'd3, d, lat);
    chk(d == 8'h00, "R12 stray data read returns zero", d, 0);
    chk(lat == 1, "R12 stray data read not stalled", lat, 1);
    chk(err_flag == 1'b1, "R12 stray data read sets error", err_flag, 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule